// File: doc/BRIEF.md
# Interleaved MD5 Compression Core

This block computes the MD5 compression function for two independent message contexts at once. Both share one round datapath: the working variables sit in a single register chain with two slots per variable. On even cycles the round logic works on context 0 and on odd cycles on context 1. Each round is split over two cycles. The first cycle forms the sum of the boolean mix, the A word, the step constant and the message word. The second cycle rotates that sum and adds it to B. Because the two contexts take turns, neither one stalls.

A host loads the sixteen message words of a 64-byte block into a context's word store through the write port. It then pulses the start strobe with a context number and a flag that picks the initial value. The initial value is either the standard MD5 constants or the digest that context produced last. After 64 steps the core adds the chaining value to the working state. It writes the four digest words to that context's result store and raises a one-cycle done pulse that names the context. Digests are held rotated by 16 bits. Reloading one as an initial value sends its B word through the shared rotator with a shift of 16, so the rotator never needs a zero-shift path. The read port undoes the rotation, so the host always sees true values. Padding and length encoding are left to the host.

Top module: `md5i_core`

## Requirements
- R1: After reset both busy bits and done are low, and every digest word of both contexts reads back as zero.
- R2: A block started with the prev flag low produces the MD5 compression of the stored 16 words using the standard initial values. Message word i is written at index i. Digest words A, B, C, D are read at indices 0, 1, 2, 3. Every word is little-endian, with byte 0 of the word in bits 7:0. For the single padded block of the empty message (word 0 = 0x00000080, all others 0), the four words are 0xd98c1dd4, 0x04b2008f, 0x980980e9, 0x7e42f8ec.
- R3: A block started with the prev flag high uses that context's last digest as its initial value and as its chaining value.
- R4: Both contexts may run at the same time, and each gives the digest it would give if it ran alone.
- R5: The phase of cycle n after reset is n mod 2. A start accepted at the end of a cycle whose phase equals the context number raises done for that context 131 cycles later. Otherwise done rises 132 cycles later. The busy bit is high from the cycle after acceptance until the cycle in which done is high.
- R6: A start for a context whose busy bit is high has no effect on that context's timing or digest.
- R7: A word write to a context whose busy bit is high is ignored.
- R8: Done is high for exactly one cycle per block, with done_ctx naming the context, and that context's busy bit is low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Block start strobe |
| start_ctx_i | input | 1 | Context to start |
| start_prev_i | input | 1 | 1: initial value from the context's last digest; 0: standard constants |
| wr_en_i | input | 1 | Message word write enable |
| wr_ctx_i | input | 1 | Context of the written word |
| wr_idx_i | input | 4 | Word index within the block |
| wr_word_i | input | 32 | Message word, little-endian |
| rd_ctx_i | input | 1 | Context of the digest read |
| rd_idx_i | input | 2 | Digest word index (0=A .. 3=D) |
| rd_word_o | output | 32 | Digest word, true value, combinational |
| busy_o | output | 2 | Per-context busy |
| done_o | output | 1 | Block finished pulse |
| done_ctx_o | output | 1 | Context that finished |

## Verification
The first pattern is the padded empty message. It has one nonzero word, so its result is a fixed value that shows whether the constant table, the shift schedule and the word order are right. Two dense, unrelated blocks then run with their starts one cycle apart. They expose any mixing between the two chain slots or the two word stores, and the start phases cover both latency cases. A write and a restart aimed at a busy context must leave both the digest and the done cycle unchanged. A second block per context with the prev flag set checks the path that reloads a rotated digest through the rotator. A cycle-level model follows every start and predicts busy and done on each clock.

// File: rtl/md5i_pkg.sv
package md5i_pkg;

    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 16;
    localparam int N_STEPS  = 64;
    localparam int N_CTX    = 2;
    localparam int N_DIG    = 4;
    localparam int STEP_W   = $clog2(N_STEPS);
    localparam int IDX_W    = $clog2(N_WORDS);
    localparam int DIG_W    = $clog2(N_DIG);
    localparam int AMT_W    = $clog2(WORD_W);
    localparam int HALF_ROT = WORD_W / 2;

    localparam logic [WORD_W-1:0] IV_A = 32'h67452301;
    localparam logic [WORD_W-1:0] IV_B = 32'hefcdab89;
    localparam logic [WORD_W-1:0] IV_C = 32'h98badcfe;
    localparam logic [WORD_W-1:0] IV_D = 32'h10325476;

    typedef enum logic [1:0] {
        CST_IDLE = 2'd0,
        CST_PEND = 2'd1,
        CST_RUN  = 2'd2,
        CST_FIN  = 2'd3
    } cst_e;

    typedef logic [N_DIG-1:0][WORD_W-1:0] dig_t;

    typedef struct packed {
        logic                         ph;
        logic [N_CTX-1:0][1:0]        cst;
        logic [N_CTX-1:0]             src;
        logic [N_CTX-1:0][STEP_W-1:0] step;
        logic [WORD_W-1:0]            a;
        logic [WORD_W-1:0]            b;
        logic [WORD_W-1:0]            b2;
        logic [WORD_W-1:0]            c;
        logic [WORD_W-1:0]            c2;
        logic [WORD_W-1:0]            d;
        logic [WORD_W-1:0]            d2;
        logic [WORD_W-1:0]            sum;
        logic [AMT_W-1:0]             samt;
        logic [N_CTX-1:0]             [N_DIG-1:0][WORD_W-1:0] iv;
        logic [N_CTX-1:0]             [N_DIG-1:0][WORD_W-1:0] dig;
        logic                         done;
        logic                         done_ctx;
    } core_regs_t;

    function automatic logic [WORD_W-1:0] md5i_rotl(logic [WORD_W-1:0] x, logic [AMT_W-1:0] n);
        return (x << n) | (x >> (6'd32 - {1'b0, n}));
    endfunction

    // boolean mix, chosen by the quarter of the block the step lies in
    function automatic logic [WORD_W-1:0] md5i_mixfn(logic [1:0] q, logic [WORD_W-1:0] x,
                                                     logic [WORD_W-1:0] y, logic [WORD_W-1:0] z);
        case (q)
            2'd0:    return (x & y) | (~x & z);
            2'd1:    return (x & z) | (y & ~z);
            2'd2:    return x ^ y ^ z;
            default: return y ^ (x | ~z);
        endcase
    endfunction

    function automatic logic [AMT_W-1:0] md5i_shift(logic [STEP_W-1:0] s);
        case ({s[5:4], s[1:0]})
            4'h0: return 5'd7;   4'h1: return 5'd12;  4'h2: return 5'd17;  4'h3: return 5'd22;
            4'h4: return 5'd5;   4'h5: return 5'd9;   4'h6: return 5'd14;  4'h7: return 5'd20;
            4'h8: return 5'd4;   4'h9: return 5'd11;  4'ha: return 5'd16;  4'hb: return 5'd23;
            4'hc: return 5'd6;   4'hd: return 5'd10;  4'he: return 5'd15;  default: return 5'd21;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] md5i_widx(logic [STEP_W-1:0] s);
        case (s[5:4])
            2'd0:    return s[3:0];
            2'd1:    return s[3:0] * 4'd5 + 4'd1;
            2'd2:    return s[3:0] * 4'd3 + 4'd5;
            default: return s[3:0] * 4'd7;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] md5i_k(logic [STEP_W-1:0] s);
        case (s)
            6'd0:  return 32'hd76aa478;  6'd1:  return 32'he8c7b756;  6'd2:  return 32'h242070db;  6'd3:  return 32'hc1bdceee;
            6'd4:  return 32'hf57c0faf;  6'd5:  return 32'h4787c62a;  6'd6:  return 32'ha8304613;  6'd7:  return 32'hfd469501;
            6'd8:  return 32'h698098d8;  6'd9:  return 32'h8b44f7af;  6'd10: return 32'hffff5bb1;  6'd11: return 32'h895cd7be;
            6'd12: return 32'h6b901122;  6'd13: return 32'hfd987193;  6'd14: return 32'ha679438e;  6'd15: return 32'h49b40821;
            6'd16: return 32'hf61e2562;  6'd17: return 32'hc040b340;  6'd18: return 32'h265e5a51;  6'd19: return 32'he9b6c7aa;
            6'd20: return 32'hd62f105d;  6'd21: return 32'h02441453;  6'd22: return 32'hd8a1e681;  6'd23: return 32'he7d3fbc8;
            6'd24: return 32'h21e1cde6;  6'd25: return 32'hc33707d6;  6'd26: return 32'hf4d50d87;  6'd27: return 32'h455a14ed;
            6'd28: return 32'ha9e3e905;  6'd29: return 32'hfcefa3f8;  6'd30: return 32'h676f02d9;  6'd31: return 32'h8d2a4c8a;
            6'd32: return 32'hfffa3942;  6'd33: return 32'h8771f681;  6'd34: return 32'h6d9d6122;  6'd35: return 32'hfde5380c;
            6'd36: return 32'ha4beea44;  6'd37: return 32'h4bdecfa9;  6'd38: return 32'hf6bb4b60;  6'd39: return 32'hbebfbc70;
            6'd40: return 32'h289b7ec6;  6'd41: return 32'heaa127fa;  6'd42: return 32'hd4ef3085;  6'd43: return 32'h04881d05;
            6'd44: return 32'hd9d4d039;  6'd45: return 32'he6db99e5;  6'd46: return 32'h1fa27cf8;  6'd47: return 32'hc4ac5665;
            6'd48: return 32'hf4292244;  6'd49: return 32'h432aff97;  6'd50: return 32'hab9423a7;  6'd51: return 32'hfc93a039;
            6'd52: return 32'h655b59c3;  6'd53: return 32'h8f0ccc92;  6'd54: return 32'hffeff47d;  6'd55: return 32'h85845dd1;
            6'd56: return 32'h6fa87e4f;  6'd57: return 32'hfe2ce6e0;  6'd58: return 32'ha3014314;  6'd59: return 32'h4e0811a1;
            6'd60: return 32'hf7537e82;  6'd61: return 32'hbd3af235;  6'd62: return 32'h2ad7d2bb;  default: return 32'heb86d391;
        endcase
    endfunction

endpackage

// File: rtl/md5i_msg_mem.sv
module md5i_msg_mem
    import md5i_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic                     wctx_i,
    input  logic [IDX_W-1:0]         widx_i,
    input  logic [WORD_W-1:0]        wdata_i,
    input  logic [N_CTX-1:0]         lock_i,
    input  logic                     rctx_i,
    input  logic [IDX_W-1:0]         ridx_i,
    output logic [WORD_W-1:0]        rdata_o
);

    logic [N_CTX-1:0][N_WORDS-1:0][WORD_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        // a context that is computing keeps its words frozen
        if (we_i && !lock_i[wctx_i]) begin
            mem_d[wctx_i][widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[rctx_i][ridx_i];

    a_r7_locked_word: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && lock_i[wctx_i]) |=> mem_q[$past(wctx_i)][$past(widx_i)] == $past(mem_q[wctx_i][widx_i]));

endmodule

// File: rtl/md5i_mix.sv
module md5i_mix
    import md5i_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    input  logic [WORD_W-1:0] d_i,
    input  logic [WORD_W-1:0] m_i,
    output logic [WORD_W-1:0] sum_o,
    output logic [AMT_W-1:0]  amt_o
);

    always_comb begin
        sum_o = md5i_mixfn(step_i[5:4], b_i, c_i, d_i) + a_i + md5i_k(step_i) + m_i;
        amt_o = md5i_shift(step_i);
    end

endmodule

// File: rtl/md5i_rotadd.sv
module md5i_rotadd
    import md5i_pkg::*;
(
    input  logic [WORD_W-1:0] x_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [WORD_W-1:0] add_i,
    output logic [WORD_W-1:0] y_o
);

    assign y_o = add_i + md5i_rotl(x_i, amt_i);

endmodule

// File: rtl/md5i_core.sv
module md5i_core
    import md5i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_ctx_i,
    input  logic              start_prev_i,
    input  logic              wr_en_i,
    input  logic              wr_ctx_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [31:0]       wr_word_i,
    input  logic              rd_ctx_i,
    input  logic [1:0]        rd_idx_i,
    output logic [31:0]       rd_word_o,
    output logic [1:0]        busy_o,
    output logic              done_o,
    output logic              done_ctx_o
);

    core_regs_t r_d, r_q;

    logic              run_ctx;   // context whose first round half runs now
    logic              ld_ctx;    // context whose chain slots are written now
    logic [WORD_W-1:0] msg_word;
    logic [WORD_W-1:0] mix_sum;
    logic [AMT_W-1:0]  mix_amt;
    logic [WORD_W-1:0] rot_x, rot_add, rot_y;
    logic [AMT_W-1:0]  rot_amt;
    logic [N_CTX-1:0]  lock;

    assign run_ctx = r_q.ph;
    assign ld_ctx  = ~r_q.ph;

    for (genvar x = 0; x < N_CTX; x++) begin : g_lock
        assign lock[x]   = r_q.cst[x] != CST_IDLE;
        assign busy_o[x] = lock[x];
    end

    md5i_msg_mem i_msg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en_i),
        .wctx_i  (wr_ctx_i),
        .widx_i  (wr_idx_i),
        .wdata_i (wr_word_i),
        .lock_i  (lock),
        .rctx_i  (run_ctx),
        .ridx_i  (md5i_widx(r_q.step[run_ctx])),
        .rdata_o (msg_word)
    );

    md5i_mix i_mix (
        .step_i (r_q.step[run_ctx]),
        .a_i    (r_q.a),
        .b_i    (r_q.b),
        .c_i    (r_q.c),
        .d_i    (r_q.d),
        .m_i    (msg_word),
        .sum_o  (mix_sum),
        .amt_o  (mix_amt)
    );

    // the single rotator: second round half, or a B initial word held rotated
    always_comb begin
        rot_x   = r_q.sum;
        rot_amt = r_q.samt;
        rot_add = r_q.b2;
        if (r_q.cst[ld_ctx] == CST_PEND) begin
            rot_x   = r_q.src[ld_ctx] ? r_q.dig[ld_ctx][1] : md5i_rotl(IV_B, 5'(HALF_ROT));
            rot_amt = 5'(HALF_ROT);
            rot_add = '0;
        end
    end

    md5i_rotadd i_rot (
        .x_i   (rot_x),
        .amt_i (rot_amt),
        .add_i (rot_add),
        .y_o   (rot_y)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ph   = ~r_q.ph;
        r_d.done = 1'b0;

        // shift chain: each variable moves two slots per round of its context
        r_d.b  = rot_y;
        r_d.b2 = r_q.b;
        r_d.c  = r_q.b2;
        r_d.c2 = r_q.c;
        r_d.d  = r_q.c2;
        r_d.d2 = r_q.d;
        r_d.a  = r_q.d2;
        r_d.sum  = mix_sum;
        r_d.samt = mix_amt;

        // initial value load into the slots of the context not in its run phase
        if (r_q.cst[ld_ctx] == CST_PEND) begin
            r_d.c = r_q.src[ld_ctx] ? md5i_rotl(r_q.dig[ld_ctx][2], 5'(HALF_ROT)) : IV_C;
            r_d.d = r_q.src[ld_ctx] ? md5i_rotl(r_q.dig[ld_ctx][3], 5'(HALF_ROT)) : IV_D;
            r_d.a = r_q.src[ld_ctx] ? md5i_rotl(r_q.dig[ld_ctx][0], 5'(HALF_ROT)) : IV_A;
            r_d.iv[ld_ctx]   = {r_d.d, r_d.c, rot_y, r_d.a};
            r_d.step[ld_ctx] = '0;
            r_d.cst[ld_ctx]  = CST_RUN;
        end

        if (r_q.cst[run_ctx] == CST_RUN) begin
            r_d.step[run_ctx] = r_q.step[run_ctx] + 6'd1;
            if (r_q.step[run_ctx] == 6'(N_STEPS - 1)) r_d.cst[run_ctx] = CST_FIN;
        end else if (r_q.cst[run_ctx] == CST_FIN) begin
            // feed-forward; digest is kept rotated by half a word
            r_d.dig[run_ctx][0] = md5i_rotl(r_q.a + r_q.iv[run_ctx][0], 5'(HALF_ROT));
            r_d.dig[run_ctx][1] = md5i_rotl(r_q.b + r_q.iv[run_ctx][1], 5'(HALF_ROT));
            r_d.dig[run_ctx][2] = md5i_rotl(r_q.c + r_q.iv[run_ctx][2], 5'(HALF_ROT));
            r_d.dig[run_ctx][3] = md5i_rotl(r_q.d + r_q.iv[run_ctx][3], 5'(HALF_ROT));
            r_d.cst[run_ctx]    = CST_IDLE;
            r_d.done            = 1'b1;
            r_d.done_ctx        = run_ctx;
        end

        if (start_i && r_q.cst[start_ctx_i] == CST_IDLE) begin
            r_d.cst[start_ctx_i] = CST_PEND;
            r_d.src[start_ctx_i] = start_prev_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.samt <= md5i_shift('0);
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_word_o  = md5i_rotl(r_q.dig[rd_ctx_i][rd_idx_i], 5'(HALF_ROT));
    assign done_o     = r_q.done;
    assign done_ctx_o = r_q.done_ctx;

    a_r2_rot_nonzero: assert property (@(posedge clk) disable iff (!rst_n) rot_amt != '0);
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o[done_ctx_o]);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !(done_o && done_ctx_o == $past(done_ctx_o)));

    for (genvar x = 0; x < N_CTX; x++) begin : g_chk
        a_r6_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
            r_q.cst[x] == CST_RUN |=> (r_q.cst[x] == CST_RUN || r_q.cst[x] == CST_FIN));
        a_r5_load_phase: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.cst[x] == CST_PEND && r_q.ph != 1'(x)) |=> (r_q.cst[x] == CST_RUN && r_q.step[x] == '0));
        a_r5_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.cst[x] == CST_RUN && r_q.ph == 1'(x) && r_q.step[x] != 6'(N_STEPS - 1))
            |=> r_q.step[x] == $past(r_q.step[x]) + 6'd1);
    end

endmodule

// File: tb/test_md5i_core.sv
module test_md5i_core;

    typedef logic [3:0][31:0]  dig_t;
    typedef logic [15:0][31:0] msg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, start_ctx_i = 1'b0, start_prev_i = 1'b0;
    logic        wr_en_i = 1'b0, wr_ctx_i = 1'b0;
    logic [3:0]  wr_idx_i = '0;
    logic [31:0] wr_word_i = '0;
    logic        rd_ctx_i = 1'b0;
    logic [1:0]  rd_idx_i = '0;
    logic [31:0] rd_word_o;
    logic [1:0]  busy_o;
    logic        done_o, done_ctx_o;

    int n_chk = 0, n_err = 0, wd = 0;

    md5i_core i_md5i_core (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .start_ctx_i(start_ctx_i), .start_prev_i(start_prev_i),
        .wr_en_i(wr_en_i), .wr_ctx_i(wr_ctx_i), .wr_idx_i(wr_idx_i), .wr_word_i(wr_word_i),
        .rd_ctx_i(rd_ctx_i), .rd_idx_i(rd_idx_i), .rd_word_o(rd_word_o),
        .busy_o(busy_o), .done_o(done_o), .done_ctx_o(done_ctx_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural MD5 reference ----------------
    int sh[4][4] = '{'{7, 12, 17, 22}, '{5, 9, 14, 20}, '{4, 11, 16, 23}, '{6, 10, 15, 21}};

    function automatic logic [31:0] kref(int i);
        real v;
        v = $sin(i + 1);
        if (v < 0.0) v = -v;
        return 32'(longint'($floor(v * 4294967296.0)));
    endfunction

    function automatic dig_t ref_compress(dig_t iv, msg_t m);
        logic [31:0] a, b, c, d, f, t;
        int g, s;
        a = iv[0]; b = iv[1]; c = iv[2]; d = iv[3];
        for (int i = 0; i < 64; i++) begin
            case (i / 16)
                0: begin f = (b & c) | (~b & d); g = i;              end
                1: begin f = (d & b) | (~d & c); g = (5 * i + 1) % 16; end
                2: begin f = b ^ c ^ d;          g = (3 * i + 5) % 16; end
                default: begin f = c ^ (b | ~d); g = (7 * i) % 16;  end
            endcase
            s = sh[i / 16][i % 4];
            t = a + f + kref(i) + m[g];
            a = d; d = c; c = b;
            b = b + ((t << s) | (t >> (32 - s)));
        end
        return {d + iv[3], c + iv[2], b + iv[1], a + iv[0]};
    endfunction

    // ---------------- cycle model of busy / done ----------------
    int  st[2];
    int  done_at[2];
    int  cyc;
    bit  ph_m;
    bit  exp_done, exp_ctx;

    always @(posedge clk) begin
        if (!rst_n) begin
            st = '{0, 0}; done_at = '{0, 0}; cyc = 0; ph_m = 1'b0;
            exp_done = 1'b0; exp_ctx = 1'b0;
        end else begin
            int old[2];
            old = st;
            exp_done = 1'b0;
            for (int x = 0; x < 2; x++) begin
                if (old[x] == 1 && ph_m != x[0]) begin
                    st[x] = 2; done_at[x] = cyc + 130;
                end
                if (old[x] == 2 && cyc + 1 == done_at[x]) begin
                    st[x] = 0; exp_done = 1'b1; exp_ctx = x[0];
                end
            end
            if (start_i && old[start_ctx_i] == 0) st[start_ctx_i] = 1;
            ph_m = ~ph_m;
            cyc++;
        end
    end

    // R5 R8: every cycle, busy and done against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int x = 0; x < 2; x++)
                chk(busy_o[x] == (st[x] != 0), "R5", $sformatf("busy ctx%0d cycle %0d", x, cyc),
                    32'(busy_o[x]), 32'(st[x] != 0));
            chk(done_o == exp_done, "R8", $sformatf("done cycle %0d", cyc), 32'(done_o), 32'(exp_done));
            if (exp_done)
                chk(done_ctx_o == exp_ctx, "R8", "done_ctx", 32'(done_ctx_o), 32'(exp_ctx));
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_msg(input bit ctx, input msg_t m);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            wr_en_i = 1'b1; wr_ctx_i = ctx; wr_idx_i = 4'(i); wr_word_i = m[i];
        end
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic start_at(input bit ctx, input bit prv, input bit want_ph);
        @(negedge clk);
        while (ph_m != want_ph) @(negedge clk);
        start_i = 1'b1; start_ctx_i = ctx; start_prev_i = prv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_free(input bit ctx);
        @(negedge clk);
        while (busy_o[ctx]) @(negedge clk);
    endtask

    task automatic check_dig(input bit ctx, input dig_t exp, input string req);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd_ctx_i = ctx; rd_idx_i = 2'(i);
            #1;
            chk(rd_word_o == exp[i], req, $sformatf("digest ctx%0d word%0d", ctx, i), rd_word_o, exp[i]);
        end
    endtask

    dig_t std_iv, d0, d1, empty_known;
    msg_t m_empty, m_a, m_b, m_c;

    initial begin
        std_iv      = {32'h10325476, 32'h98badcfe, 32'hefcdab89, 32'h67452301};
        empty_known = {32'h7e42f8ec, 32'h980980e9, 32'h04b2008f, 32'hd98c1dd4};
        m_empty = '0; m_empty[0] = 32'h00000080;
        for (int i = 0; i < 16; i++) begin
            m_a[i] = 32'h9e3779b9 * (i + 1) ^ 32'h0badf00d;
            m_b[i] = {8'(i), 8'(i * 3), 8'(255 - i), 8'(i * 17)};
            m_c[i] = 32'hc3a5c3a5 + 32'(i * 32'h01010101);
        end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy_o == 2'b00, "R1", "busy after reset", 32'(busy_o), 0);
        chk(done_o == 1'b0, "R1", "done after reset", 32'(done_o), 0);
        for (int x = 0; x < 2; x++)
            for (int i = 0; i < 4; i++) begin
                rd_ctx_i = x[0]; rd_idx_i = 2'(i);
                #1;
                chk(rd_word_o == 0, "R1", $sformatf("digest ctx%0d word%0d after reset", x, i), rd_word_o, 0);
            end

        // R2: padded empty message, start in the phase equal to the context
        write_msg(1'b0, m_empty);
        start_at(1'b0, 1'b0, 1'b0);
        wait_free(1'b0);
        check_dig(1'b0, empty_known, "R2");
        check_dig(1'b0, ref_compress(std_iv, m_empty), "R2");

        // R4: two dense blocks overlapping; other latency case for ctx0
        write_msg(1'b0, m_a);
        write_msg(1'b1, m_b);
        start_at(1'b0, 1'b0, 1'b1);
        start_i = 1'b1; start_ctx_i = 1'b1; start_prev_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        // R7: write into a busy context
        wr_en_i = 1'b1; wr_ctx_i = 1'b0; wr_idx_i = 4'd5; wr_word_i = 32'hdeadbeef;
        @(negedge clk);
        wr_en_i = 1'b0;
        // R6: restart attempt on a busy context
        start_i = 1'b1; start_ctx_i = 1'b0; start_prev_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_free(1'b0);
        wait_free(1'b1);
        d0 = ref_compress(std_iv, m_a);
        d1 = ref_compress(std_iv, m_b);
        check_dig(1'b0, d0, "R4 R6 R7");
        check_dig(1'b1, d1, "R4");

        // R3: chained blocks from each context's own last digest
        write_msg(1'b1, m_c);
        start_at(1'b1, 1'b1, 1'b1);
        start_i = 1'b1; start_ctx_i = 1'b0; start_prev_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_free(1'b1);
        wait_free(1'b0);
        check_dig(1'b1, ref_compress(d1, m_c), "R3");
        check_dig(1'b0, ref_compress(d0, m_a), "R3 R7");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule